// File: doc/BRIEF.md
# Block-Granular Digest Tracker and Comparator

This block watches a stream of masked configuration readback words and groups them into blocks, each made of a fixed number of consecutive frames. The words of a block are packed into wide message chunks. The chunks go to an external hash engine over a one-way message interface, and the last chunk of every block is flagged so the engine can close the digest. Each digest the engine returns is filed into a table of current digests, at the number of the block it belongs to. In the same cycle it is compared with a trusted digest for that block. Trusted digests are written in beforehand through a load port.

Block numbers count upward in readback order. That order runs from the lower-left corner of the device to the upper-right, so a block number points to a physical region. After the last block of a pass, numbering starts again at zero and checking carries on without a break. A mismatch raises an alarm and reports the failing block number. Software can read any entry of the current table and clears the alarm when it has dealt with it.

The hash engine must accept a chunk in every cycle in which one is offered. It must return digests in the order in which blocks were closed. By default a block is 20 frames, a pass is 168 blocks, digests are 128 bits and chunks are 512 bits.

Top module: `hash_block_tracker`

## Requirements
- R1: Readback words are packed into a chunk lowest word first: the first word of a chunk sits in bits [WORD_W-1:0], the next word in the next WORD_W bits, and so on. A chunk is sent as soon as CHUNK_W/WORD_W words have been collected.
- R2: The word that carries the end-of-frame marker for the FRAMES-th frame of a block closes the current chunk at once. The bits not yet filled in that chunk are zero, and msg_last is 1 with it. On every other chunk msg_last is 0.
- R3: msg_valid is 1 for exactly one cycle, in the cycle after the input word that completes a chunk. After any other input word, and after cycles with no input word, msg_valid is 0.
- R4: Each returned digest is written into the current table at the block number it belongs to. From the cycle after its arrival, that entry can be read through cur_rd_idx and cur_rd_value with no added latency.
- R5: Digests are matched to blocks in arrival order: 0, 1, …, NUM_BLOCKS-1. After NUM_BLOCKS-1 the count returns to 0, so the first digest of the next pass updates entry 0.
- R6: When a returned digest differs from the trusted entry of its block, alarm is 1 from the next cycle and alarm_idx holds that block number. A digest that matches never raises the alarm.
- R7: While alarm is 1, a later mismatch replaces alarm_idx only if its block number is lower, so the lowest failing number is kept. alarm_clr drops alarm in the next cycle. If a mismatch arrives in the same cycle as alarm_clr, the alarm is set again and takes the new block number.
- R8: With tl_we set, tl_value is written into the trusted table at entry tl_idx. Later comparisons for that block use the new value.
- R9: While reset is active, and in the first cycles after it is released, msg_valid, msg_last and alarm are 0, and packing and block counting start from word 0 of block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rb_valid | input | 1 | A masked readback word is present |
| rb_word | input | WORD_W | Masked readback word |
| rb_frame_end | input | 1 | This word is the last word of a frame |
| msg_valid | output | 1 | Chunk to the hash engine is valid |
| msg_chunk | output | CHUNK_W | Chunk data, first word in the low bits |
| msg_last | output | 1 | Chunk is the final one of a block |
| dig_valid | input | 1 | Hash engine returns a digest |
| dig_value | input | DIG_W | Returned digest |
| tl_we | input | 1 | Trusted-table write enable |
| tl_idx | input | IDX_W | Trusted-table entry to write |
| tl_value | input | DIG_W | Trusted digest to write |
| cur_rd_idx | input | IDX_W | Current-table entry to read |
| cur_rd_value | output | DIG_W | Current digest of the selected entry |
| alarm | output | 1 | A mismatch has been seen and not yet cleared |
| alarm_idx | output | IDX_W | Lowest failing block number held |
| alarm_clr | input | 1 | Clears the alarm |

## Verification
Suppose the frame counter or the word slot inside a chunk drifts. Then a chunk boundary or the msg_last flag moves, and the scoreboard sees a chunk that differs from the expected one within the same block. If the digest block counter slips or fails to wrap, digests land in the wrong entry. A clean pass then raises a false alarm with a wrong block number, or a corrupted block shows up at the wrong current-table entry once the next pass ends. Errors in the alarm priority show up at the end of the pass that has two failing blocks, as a wrong alarm_idx, or after a clear as an alarm that does not drop.

// File: rtl/hbt_pkg.sv
package hbt_pkg;

  // Width of an index that must hold values 0 .. count-1; never below one bit.
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/hbt_frame_grouper.sv
module hbt_frame_grouper
  import hbt_pkg::*;
#(
  parameter int FRAMES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic frame_end,
  output logic blk_end
);

  localparam int FW = idx_width(FRAMES);

  logic [FW-1:0] fcnt_q, fcnt_d;
  logic          fcnt_en;

  assign blk_end = in_valid && frame_end && (fcnt_q == FW'(FRAMES - 1));
  assign fcnt_en = in_valid && frame_end;

  always_comb begin
    fcnt_d = fcnt_q;
    if (blk_end) begin
      fcnt_d = '0;
    end else begin
      fcnt_d = fcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
    end else if (fcnt_en) begin
      fcnt_q <= fcnt_d;
    end
  end

  AST_FRAME_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fcnt_q) < FRAMES); // R2

endmodule

// File: rtl/hbt_chunk_packer.sv
module hbt_chunk_packer
  import hbt_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int CHUNK_W = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_word,
  input  logic               blk_end,
  output logic               msg_valid,
  output logic [CHUNK_W-1:0] msg_chunk,
  output logic               msg_last
);

  localparam int WPC = CHUNK_W / WORD_W;
  localparam int CW  = idx_width(WPC);

  logic [CHUNK_W-1:0] acc_q, acc_d, merged;
  logic [CW-1:0]      slot_q, slot_d;
  logic               emit;
  logic               vld_q, last_q, last_d;
  logic [CHUNK_W-1:0] data_q;

  always_comb begin
    merged = acc_q;
    merged[int'(slot_q)*WORD_W +: WORD_W] = in_word;
  end

  assign emit = in_valid && ((slot_q == CW'(WPC - 1)) || blk_end);

  always_comb begin
    acc_d  = acc_q;
    slot_d = slot_q;
    if (emit) begin
      acc_d  = '0;
      slot_d = '0;
    end else if (in_valid) begin
      acc_d  = merged;
      slot_d = slot_q + 1'b1;
    end
    last_d = emit && blk_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      slot_q <= '0;
    end else if (in_valid) begin
      acc_q  <= acc_d;
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= emit;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (emit) begin
      data_q <= merged;
    end
  end

  assign msg_valid = vld_q;
  assign msg_chunk = data_q;
  assign msg_last  = last_q;

  AST_MSG_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(in_valid)); // R3
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> vld_q); // R2

endmodule

// File: rtl/hbt_digest_tables.sv
module hbt_digest_tables
  import hbt_pkg::*;
#(
  parameter int DIG_W      = 128,
  parameter int NUM_BLOCKS = 168
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               dig_valid,
  input  logic [DIG_W-1:0]                   dig_value,
  input  logic                               tl_we,
  input  logic [idx_width(NUM_BLOCKS)-1:0]   tl_idx,
  input  logic [DIG_W-1:0]                   tl_value,
  input  logic [idx_width(NUM_BLOCKS)-1:0]   cur_rd_idx,
  output logic [DIG_W-1:0]                   cur_rd_value,
  input  logic                               clr,
  output logic                               alarm,
  output logic [idx_width(NUM_BLOCKS)-1:0]   alarm_idx
);

  localparam int IW = idx_width(NUM_BLOCKS);

  logic [DIG_W-1:0] trust_tab [NUM_BLOCKS];
  logic [DIG_W-1:0] cur_tab   [NUM_BLOCKS];

  logic [IW-1:0] blk_q, blk_d;
  logic          mismatch, take;
  logic          alarm_q, alarm_d;
  logic [IW-1:0] aidx_q, aidx_d;

  assign blk_d    = (blk_q == IW'(NUM_BLOCKS - 1)) ? '0 : blk_q + 1'b1;
  assign mismatch = dig_valid && (dig_value != trust_tab[blk_q]);
  assign take     = mismatch && (clr || !alarm_q || (blk_q < aidx_q));

  always_comb begin
    alarm_d = alarm_q;
    aidx_d  = aidx_q;
    if (take) begin
      alarm_d = 1'b1;
      aidx_d  = blk_q;
    end else if (clr) begin
      alarm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q   <= '0;
      alarm_q <= 1'b0;
      aidx_q  <= '0;
    end else begin
      if (dig_valid) begin
        blk_q <= blk_d;
      end
      alarm_q <= alarm_d;
      aidx_q  <= aidx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dig_valid) begin
      cur_tab[blk_q] <= dig_value;
    end
    if (tl_we && (int'(tl_idx) < NUM_BLOCKS)) begin
      trust_tab[tl_idx] <= tl_value;
    end
  end

  assign cur_rd_value = cur_tab[cur_rd_idx];
  assign alarm        = alarm_q;
  assign alarm_idx    = aidx_q;

  AST_BLK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(blk_q) < NUM_BLOCKS); // R5
  AST_ALARM_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> $past(dig_valid)); // R6
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && !clr && !dig_valid) |=> (alarm_q && $stable(aidx_q))); // R7
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !dig_valid) |=> !alarm_q); // R7

endmodule

// File: rtl/hash_block_tracker.sv
module hash_block_tracker
  import hbt_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CHUNK_W    = 512,
  parameter int DIG_W      = 128,
  parameter int FRAMES     = 20,
  parameter int NUM_BLOCKS = 168,
  parameter int IDX_W      = idx_width(NUM_BLOCKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rb_valid,
  input  logic [WORD_W-1:0]  rb_word,
  input  logic               rb_frame_end,
  output logic               msg_valid,
  output logic [CHUNK_W-1:0] msg_chunk,
  output logic               msg_last,
  input  logic               dig_valid,
  input  logic [DIG_W-1:0]   dig_value,
  input  logic               tl_we,
  input  logic [IDX_W-1:0]   tl_idx,
  input  logic [DIG_W-1:0]   tl_value,
  input  logic [IDX_W-1:0]   cur_rd_idx,
  output logic [DIG_W-1:0]   cur_rd_value,
  output logic               alarm,
  output logic [IDX_W-1:0]   alarm_idx,
  input  logic               alarm_clr
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       blk_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  hbt_frame_grouper #(.FRAMES(FRAMES)) u_grouper (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (rb_valid),
    .frame_end (rb_frame_end),
    .blk_end   (blk_end)
  );

  hbt_chunk_packer #(.WORD_W(WORD_W), .CHUNK_W(CHUNK_W)) u_packer (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (rb_valid),
    .in_word   (rb_word),
    .blk_end   (blk_end),
    .msg_valid (msg_valid),
    .msg_chunk (msg_chunk),
    .msg_last  (msg_last)
  );

  hbt_digest_tables #(.DIG_W(DIG_W), .NUM_BLOCKS(NUM_BLOCKS)) u_tables (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .dig_valid    (dig_valid),
    .dig_value    (dig_value),
    .tl_we        (tl_we),
    .tl_idx       (tl_idx),
    .tl_value     (tl_value),
    .cur_rd_idx   (cur_rd_idx),
    .cur_rd_value (cur_rd_value),
    .clr          (alarm_clr),
    .alarm        (alarm),
    .alarm_idx    (alarm_idx)
  );

endmodule

// File: tb/hash_block_tracker_tb.sv
module hash_block_tracker_tb;

  localparam int WORD_W = 32;
  localparam int CHUNK_W = 128;
  localparam int DIG_W = 32;
  localparam int FRAMES = 2;
  localparam int NB = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rb_valid = 1'b0;
  logic [WORD_W-1:0] rb_word = '0;
  logic rb_frame_end = 1'b0;
  logic msg_valid, msg_last;
  logic [CHUNK_W-1:0] msg_chunk;
  logic dig_valid = 1'b0;
  logic [DIG_W-1:0] dig_value = '0;
  logic tl_we = 1'b0;
  logic [IW-1:0] tl_idx = '0;
  logic [DIG_W-1:0] tl_value = '0;
  logic [IW-1:0] cur_rd_idx = '0;
  logic [DIG_W-1:0] cur_rd_value;
  logic alarm;
  logic [IW-1:0] alarm_idx;
  logic alarm_clr = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [CHUNK_W:0] exp_q[$];
  logic [31:0] hacc = 32'h0123_4567;

  always #10 clk = ~clk;

  hash_block_tracker #(.WORD_W(WORD_W), .CHUNK_W(CHUNK_W), .DIG_W(DIG_W),
    .FRAMES(FRAMES), .NUM_BLOCKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .rb_valid(rb_valid), .rb_word(rb_word),
    .rb_frame_end(rb_frame_end), .msg_valid(msg_valid), .msg_chunk(msg_chunk),
    .msg_last(msg_last), .dig_valid(dig_valid), .dig_value(dig_value),
    .tl_we(tl_we), .tl_idx(tl_idx), .tl_value(tl_value), .cur_rd_idx(cur_rd_idx),
    .cur_rd_value(cur_rd_value), .alarm(alarm), .alarm_idx(alarm_idx),
    .alarm_clr(alarm_clr));

  task automatic check(input string req, input logic [CHUNK_W:0] act, input logic [CHUNK_W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int b, input int i, input bit bad);
    logic [31:0] w;
    w = {8'hB0 ^ 8'(b), 8'(i), 16'hC3A5 ^ 16'(b * 7 + i)};
    if (bad && i == 4) w[0] = ~w[0];
    return w;
  endfunction

  function automatic logic [31:0] fold(input logic [31:0] acc, input logic [CHUNK_W-1:0] c);
    return {acc[26:0], acc[31:27]} ^ c[31:0] ^ c[63:32] ^ c[95:64] ^ c[127:96];
  endfunction

  // Stand-in hash of one block: 6 words (3 per frame) -> chunk of 4 words, chunk of 2 padded
  function automatic logic [31:0] blk_digest(input int b, input bit bad);
    logic [CHUNK_W-1:0] c0, c1;
    c0 = {word_of(b, 3, bad), word_of(b, 2, bad), word_of(b, 1, bad), word_of(b, 0, bad)};
    c1 = {64'h0, word_of(b, 5, bad), word_of(b, 4, bad)};
    return fold(fold(32'h0123_4567, c0), c1);
  endfunction

  // Monitor and stand-in hash engine
  always @(negedge clk) begin
    cycles++;
    if (dig_valid) dig_valid <= 1'b0;
    if (msg_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected chunk", {msg_last, msg_chunk}, '0);
      end else begin
        logic [CHUNK_W:0] e;
        e = exp_q.pop_front();
        check(e[CHUNK_W] ? "R2 block-final chunk" : "R1 packed chunk", {msg_last, msg_chunk}, e);
      end
      if (msg_last) begin
        dig_valid <= 1'b1;
        dig_value <= fold(hacc, msg_chunk);
        hacc = 32'h0123_4567;
      end else begin
        hacc = fold(hacc, msg_chunk);
      end
    end
  end

  task automatic send_block(input int b, input bit bad);
    logic [CHUNK_W-1:0] c0;
    c0 = {word_of(b, 3, bad), word_of(b, 2, bad), word_of(b, 1, bad), word_of(b, 0, bad)};
    exp_q.push_back({1'b0, c0});
    exp_q.push_back({1'b1, 64'h0, word_of(b, 5, bad), word_of(b, 4, bad)});
    for (int i = 0; i < 6; i++) begin
      rb_valid = 1'b1;
      rb_word = word_of(b, i, bad);
      rb_frame_end = (i == 2 || i == 5);
      @(negedge clk);
      rb_valid = 1'b0;
      rb_frame_end = 1'b0;
      check("R3 chunk strobe timing", {128'h0, msg_valid}, {128'h0, (i == 3 || i == 5)});
      if (i == 1) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_pass(input int bad_a, input int bad_b);
    for (int b = 0; b < NB; b++) send_block(b, (b == bad_a) || (b == bad_b));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset msg_valid", {128'h0, msg_valid}, '0);
    check("R9 reset alarm", {128'h0, alarm}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 post-reset alarm", {128'h0, alarm}, '0);
    // R8: preload trusted digests
    for (int b = 0; b < NB; b++) begin
      tl_we = 1'b1; tl_idx = IW'(b); tl_value = blk_digest(b, 1'b0);
      @(negedge clk);
    end
    tl_we = 1'b0;
    run_pass(-1, -1);
    check("R6 R8 clean pass no alarm", {128'h0, alarm}, '0);
    for (int b = 0; b < NB; b++) begin
      cur_rd_idx = IW'(b);
      #1;
      check("R4 current digest", {97'h0, cur_rd_value}, {97'h0, blk_digest(b, 1'b0)});
    end
    run_pass(2, -1);
    check("R6 alarm raised", {128'h0, alarm}, {128'h0, 1'b1});
    check("R6 alarm index", {127'h0, alarm_idx}, {127'h0, 2'd2});
    cur_rd_idx = 2'd2; #1;
    check("R5 wrapped pass writes entry 2", {97'h0, cur_rd_value}, {97'h0, blk_digest(2, 1'b1)});
    cur_rd_idx = 2'd0; #1;
    check("R5 wrapped pass entry 0", {97'h0, cur_rd_value}, {97'h0, blk_digest(0, 1'b0)});
    run_pass(1, 3);
    check("R7 lowest index kept", {127'h0, alarm_idx}, {127'h0, 2'd1});
    check("R7 alarm still held", {128'h0, alarm}, {128'h0, 1'b1});
    alarm_clr = 1'b1;
    @(negedge clk);
    alarm_clr = 1'b0;
    check("R7 clear drops alarm", {128'h0, alarm}, '0);
    run_pass(-1, -1);
    check("R6 clean pass after clear", {128'h0, alarm}, '0);
    cur_rd_idx = 2'd2; #1;
    check("R4 entry 2 refreshed", {97'h0, cur_rd_value}, {97'h0, blk_digest(2, 1'b0)});
    check("R1 all chunks emitted", {96'h0, 32'(exp_q.size())}, '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule